// File: doc/BRIEF.md
# HDLC Receive Bitstream Deframer

This block takes an already demodulated and NRZI-decoded serial bit stream, one bit per `bit_valid` strobe. It finds frame delimiters and discards the zero bits that the sender inserted after runs of five ones. It rebuilds data bytes least significant bit first and writes them into a downstream FIFO through a push/full pair. Every delimiter seen is forwarded as a marker byte `0x7E`. A data byte that happens to equal a control value (`0x7E`, `0x7F` or `0x1B`) is written as the escape byte `0x1B` followed by the byte itself. A consumer reading the FIFO can therefore always tell payload apart from delimiters.

A run of seven ones aborts the frame, and the block then ignores the stream until the next delimiter. When a push meets a full FIFO, the byte is lost, reception stops until the next delimiter, and a sticky overrun flag is raised. Software clears that flag with `ovr_clr`. The decision order for each bit is fixed: the delimiter test comes first, then the abort test, then the idle test, then the stuffed-bit test.

Top module: `hdlc_deframer`

## Requirements
- R1: Each strobe shifts `bit_in` into bit 0 of an 8-bit history register. When the history with the new bit equals 0x7E, the block pushes 0x7E in that same cycle, sets `receiving` from the next cycle, and restarts byte assembly.
- R2: If `fifo_full` is high in the cycle of a delimiter, no push occurs, `receiving` is low from the next cycle, and `overrun` is set.
- R3: If the history is not 0x7E but its low seven bits are all ones, `receiving` is low from the next cycle.
- R4: While `receiving` is low, any bit that does not complete a delimiter causes no push.
- R5: While receiving, a bit for which the low six history bits are 0b111110 is discarded and does not count toward a byte.
- R6: Data bits are assembled least significant bit first. On the eighth data bit, a byte that is not a control value is pushed in that strobe's cycle.
- R7: A completed byte equal to 0x7E, 0x7F or 0x1B causes a push of 0x1B in the strobe's cycle and a push of the byte itself in the following cycle.
- R8: `push_valid` is never high while `fifo_full` is high. Any push that meets a full FIFO is dropped, clears `receiving` and sets `overrun`. `overrun` then stays set until it is cleared.
- R9: `ovr_clr` clears `overrun` unless a push fails in the same cycle. Reset clears the history, `receiving`, `overrun` and any pending escaped byte.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bit_valid | input | 1 | Strobe: `bit_in` carries a new decoded bit |
| bit_in | input | 1 | Decoded serial bit |
| fifo_full | input | 1 | Downstream FIFO cannot accept a push this cycle |
| ovr_clr | input | 1 | Clears the sticky overrun flag |
| push_valid | output | 1 | Writes `push_data` into the FIFO this cycle |
| push_data | output | 8 | Byte being written |
| receiving | output | 1 | Inside a frame, after a delimiter |
| overrun | output | 1 | Sticky: a push was lost to a full FIFO |

## Verification
The checker assumes that two `bit_valid` strobes are never adjacent. This leaves the cycle after an escape free for the escaped byte, and a property states it as an input rule. The stimulus always follows each strobe with one idle cycle. The properties also assume that `fifo_full` is only sampled, so the bench drives it freely per cycle, including high in the cycle of a delimiter and in the cycle of the deferred escaped byte.

// File: rtl/hdlc_dfr_pkg.sv
package hdlc_dfr_pkg;

  localparam int BYTE_W = 8;
  localparam int IDX_W  = $clog2(BYTE_W);

  typedef enum logic [2:0] {
    EV_NONE,
    EV_FLAG,
    EV_ABORT,
    EV_IDLE,
    EV_STUFF,
    EV_DATA
  } bit_event_e;

  // mask with the n lowest bits set
  function automatic logic [BYTE_W-1:0] low_ones(input int n);
    logic [BYTE_W-1:0] m;
    m = '0;
    for (int i = 0; i < BYTE_W; i++) begin
      if (i < n) m[i] = 1'b1;
    end
    return m;
  endfunction

  // decision for one bit, in priority order: delimiter, abort, idle, stuffed, data
  function automatic bit_event_e classify_bit(input logic [BYTE_W-1:0] hist,
                                              input logic rx,
                                              input logic [BYTE_W-1:0] flag_code,
                                              input int abort_run,
                                              input int stuff_run);
    logic [BYTE_W-1:0] abort_m;
    logic [BYTE_W-1:0] stuff_m;
    logic [BYTE_W-1:0] stuff_v;
    abort_m = low_ones(abort_run);
    stuff_m = low_ones(stuff_run + 1);
    stuff_v = stuff_m & ~low_ones(1);
    if (hist == flag_code)                 return EV_FLAG;
    else if ((hist & abort_m) == abort_m)  return EV_ABORT;
    else if (!rx)                          return EV_IDLE;
    else if ((hist & stuff_m) == stuff_v)  return EV_STUFF;
    else                                   return EV_DATA;
  endfunction

  function automatic logic needs_escape(input logic [BYTE_W-1:0] b,
                                        input logic [BYTE_W-1:0] flag_code,
                                        input logic [BYTE_W-1:0] abort_code,
                                        input logic [BYTE_W-1:0] esc_code);
    return (b == flag_code) || (b == abort_code) || (b == esc_code);
  endfunction

  // place a new bit at the top of the assembler (LSB-first arrival)
  function automatic logic [BYTE_W-1:0] merge_bit(input logic [BYTE_W-1:0] acc,
                                                  input logic b);
    logic [BYTE_W-1:0] r;
    r = acc;
    if (b) r[BYTE_W-1] = 1'b1;
    return r;
  endfunction

endpackage

// File: rtl/hdlc_dfr_history.sv
module hdlc_dfr_history
  import hdlc_dfr_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              shift_en,
  input  logic              bit_in,
  output logic [BYTE_W-1:0] hist_next
);

  logic [BYTE_W-1:0] hist_q;

  assign hist_next = {hist_q[BYTE_W-2:0], bit_in};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        hist_q <= '0;
    else if (shift_en) hist_q <= hist_next;
  end

endmodule

// File: rtl/hdlc_dfr_assembler.sv
module hdlc_dfr_assembler
  import hdlc_dfr_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              restart,
  input  logic              take_bit,
  input  logic              bit_in,
  output logic              byte_done,
  output logic [BYTE_W-1:0] byte_out
);

  localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(BYTE_W - 1);

  logic [BYTE_W-1:0] acc_q;
  logic [IDX_W-1:0]  idx_q;

  assign byte_out  = merge_bit(acc_q, bit_in);
  assign byte_done = take_bit && (idx_q == LAST_IDX);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      acc_q <= '0;
      idx_q <= '0;
    end else if (restart || byte_done) begin
      acc_q <= '0;
      idx_q <= '0;
    end else if (take_bit) begin
      acc_q <= byte_out >> 1;
      idx_q <= idx_q + 1'b1;
    end
  end

endmodule

// File: rtl/hdlc_dfr_emitter.sv
module hdlc_dfr_emitter
  import hdlc_dfr_pkg::*;
#(
  parameter logic [BYTE_W-1:0] FLAG_CODE  = 8'h7E,
  parameter logic [BYTE_W-1:0] ABORT_CODE = 8'h7F,
  parameter logic [BYTE_W-1:0] ESC_CODE   = 8'h1B
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              flag_evt,
  input  logic              byte_done,
  input  logic [BYTE_W-1:0] byte_val,
  input  logic              fifo_full,
  output logic              push_valid,
  output logic [BYTE_W-1:0] push_data,
  output logic              push_fail,
  output logic              esc_pending
);

  logic              pend_q;
  logic [BYTE_W-1:0] pend_byte_q;
  logic              esc_needed;
  logic              want;
  logic [BYTE_W-1:0] want_data;

  assign esc_needed = byte_done && needs_escape(byte_val, FLAG_CODE, ABORT_CODE, ESC_CODE);

  always_comb begin
    want      = 1'b0;
    want_data = '0;
    if (pend_q) begin
      want      = 1'b1;
      want_data = pend_byte_q;
    end else if (flag_evt) begin
      want      = 1'b1;
      want_data = FLAG_CODE;
    end else if (byte_done) begin
      want      = 1'b1;
      want_data = esc_needed ? ESC_CODE : byte_val;
    end
  end

  assign push_valid  = want && !fifo_full;
  assign push_fail   = want && fifo_full;
  assign push_data   = want_data;
  assign esc_pending = pend_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pend_q      <= 1'b0;
      pend_byte_q <= '0;
    end else begin
      pend_q <= !pend_q && esc_needed && !fifo_full;
      if (esc_needed) pend_byte_q <= byte_val;
    end
  end

endmodule

// File: rtl/hdlc_deframer.sv
module hdlc_deframer
  import hdlc_dfr_pkg::*;
#(
  parameter logic [BYTE_W-1:0] FLAG_CODE  = 8'h7E,
  parameter logic [BYTE_W-1:0] ABORT_CODE = 8'h7F,
  parameter logic [BYTE_W-1:0] ESC_CODE   = 8'h1B,
  parameter int                ABORT_RUN  = 7,
  parameter int                STUFF_RUN  = 5
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bit_valid,
  input  logic              bit_in,
  input  logic              fifo_full,
  input  logic              ovr_clr,
  output logic              push_valid,
  output logic [BYTE_W-1:0] push_data,
  output logic              receiving,
  output logic              overrun
);

  logic [BYTE_W-1:0] hist_next;
  bit_event_e        ev;
  logic              flag_evt;
  logic              abort_evt;
  logic              take_bit;
  logic              byte_done;
  logic [BYTE_W-1:0] byte_val;
  logic              push_fail;
  logic              esc_pending;
  logic              rx_q;
  logic              ovr_q;

  hdlc_dfr_history u_hist (
    .clk       (clk),
    .rst_n     (rst_n),
    .shift_en  (bit_valid),
    .bit_in    (bit_in),
    .hist_next (hist_next)
  );

  assign ev        = classify_bit(hist_next, rx_q, FLAG_CODE, ABORT_RUN, STUFF_RUN);
  assign flag_evt  = bit_valid && (ev == EV_FLAG);
  assign abort_evt = bit_valid && (ev == EV_ABORT);
  assign take_bit  = bit_valid && (ev == EV_DATA);

  hdlc_dfr_assembler u_asm (
    .clk       (clk),
    .rst_n     (rst_n),
    .restart   (flag_evt),
    .take_bit  (take_bit),
    .bit_in    (bit_in),
    .byte_done (byte_done),
    .byte_out  (byte_val)
  );

  hdlc_dfr_emitter #(
    .FLAG_CODE  (FLAG_CODE),
    .ABORT_CODE (ABORT_CODE),
    .ESC_CODE   (ESC_CODE)
  ) u_emit (
    .clk         (clk),
    .rst_n       (rst_n),
    .flag_evt    (flag_evt),
    .byte_done   (byte_done),
    .byte_val    (byte_val),
    .fifo_full   (fifo_full),
    .push_valid  (push_valid),
    .push_data   (push_data),
    .push_fail   (push_fail),
    .esc_pending (esc_pending)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rx_q  <= 1'b0;
      ovr_q <= 1'b0;
    end else begin
      if (push_fail)      rx_q <= 1'b0;
      else if (flag_evt)  rx_q <= 1'b1;
      else if (abort_evt) rx_q <= 1'b0;

      if (push_fail)      ovr_q <= 1'b1;
      else if (ovr_clr)   ovr_q <= 1'b0;
    end
  end

  assign receiving = rx_q;
  assign overrun   = ovr_q;

endmodule

// File: rtl/hdlc_deframer_chk.sv
module hdlc_deframer_chk #(
  parameter logic [7:0] FLAG_CODE = 8'h7E
) (
  input logic       clk,
  input logic       rst_n,
  input logic       bit_valid,
  input logic       fifo_full,
  input logic       ovr_clr,
  input logic       push_valid,
  input logic [7:0] push_data,
  input logic       receiving,
  input logic       overrun,
  input logic       flag_evt,
  input logic       abort_evt,
  input logic       push_fail,
  input logic       esc_pending
);

  // R1
  flag_push_chk: assert property (@(posedge clk) disable iff (!rst_n)
    flag_evt && !fifo_full && !esc_pending |-> push_valid && push_data == FLAG_CODE);

  // R1
  flag_enter_chk: assert property (@(posedge clk) disable iff (!rst_n)
    flag_evt && !fifo_full && !esc_pending |=> receiving);

  // R2
  flag_full_chk: assert property (@(posedge clk) disable iff (!rst_n)
    flag_evt && fifo_full |=> overrun && !receiving);

  // R3
  abort_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    abort_evt |=> !receiving);

  // R4
  idle_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !receiving && !flag_evt && !esc_pending |-> !push_valid);

  // R7
  strobe_gap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    esc_pending |-> !bit_valid);

  // R8
  no_push_full_chk: assert property (@(posedge clk) disable iff (!rst_n)
    fifo_full |-> !push_valid);

  // R8
  fail_flags_chk: assert property (@(posedge clk) disable iff (!rst_n)
    push_fail |=> overrun && !receiving);

  // R8
  ovr_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    overrun && !ovr_clr |=> overrun);

  // R9
  ovr_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ovr_clr && !push_fail |=> !overrun);

endmodule

bind hdlc_deframer hdlc_deframer_chk #(.FLAG_CODE(FLAG_CODE)) u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .bit_valid   (bit_valid),
  .fifo_full   (fifo_full),
  .ovr_clr     (ovr_clr),
  .push_valid  (push_valid),
  .push_data   (push_data),
  .receiving   (receiving),
  .overrun     (overrun),
  .flag_evt    (flag_evt),
  .abort_evt   (abort_evt),
  .push_fail   (push_fail),
  .esc_pending (esc_pending)
);

// File: tb/tb_hdlc_deframer.sv
module tb_hdlc_deframer;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       bit_valid = 1'b0;
  logic       bit_in = 1'b0;
  logic       fifo_full = 1'b0;
  logic       ovr_clr = 1'b0;
  logic       push_valid;
  logic [7:0] push_data;
  logic       receiving;
  logic       overrun;

  always #4 clk = ~clk;

  hdlc_deframer dut (
    .clk        (clk),
    .rst_n      (rst_n),
    .bit_valid  (bit_valid),
    .bit_in     (bit_in),
    .fifo_full  (fifo_full),
    .ovr_clr    (ovr_clr),
    .push_valid (push_valid),
    .push_data  (push_data),
    .receiving  (receiving),
    .overrun    (overrun)
  );

  int    n_cmp = 0;
  int    n_bad = 0;
  string cur_req = "R9";

  // reference model state
  int m_hist = 0, m_rx = 0, m_ovr = 0, m_acc = 0, m_idx = 0;
  int m_pend[$];
  int ones_run = 0;
  bit bq[$];
  int lfsr = 32'h1ACE;

  task automatic check(input int ev, input int ed);
    n_cmp++;
    if (push_valid !== ev[0] || (ev != 0 && push_data !== ed[7:0]) ||
        receiving !== m_rx[0] || overrun !== m_ovr[0]) begin
      n_bad++;
      $display("FAIL %s: got v=%0b d=%02h rx=%0b ovr=%0b, expected v=%0b d=%02h rx=%0b ovr=%0b",
               cur_req, push_valid, push_data, receiving, overrun, ev[0], ed[7:0], m_rx[0], m_ovr[0]);
    end
  endtask

  task automatic cycle(input bit bv, input bit b, input bit f, input bit clr, input bit rst);
    int ev, ed, fail, rx_n, h;
    @(negedge clk);
    rst_n = !rst; bit_valid = bv; bit_in = b; fifo_full = f; ovr_clr = clr;
    #1;
    ev = 0; ed = 0; fail = 0;
    if (rst) begin
      m_hist = 0; m_rx = 0; m_ovr = 0; m_acc = 0; m_idx = 0; m_pend.delete();
      check(0, 0);
      return;
    end
    rx_n = m_rx;
    if (m_pend.size() > 0) begin
      ed = m_pend.pop_front();
      if (f) fail = 1; else ev = 1;
    end else if (bv) begin
      h = ((m_hist << 1) | int'(b)) & 255;
      m_hist = h;
      if (h == 8'h7E) begin
        if (f) fail = 1; else begin ev = 1; ed = 8'h7E; end
        rx_n = 1; m_acc = 0; m_idx = 0;
      end else if ((h & 127) == 127) begin
        rx_n = 0;
      end else if (m_rx == 0) begin
        // ignored
      end else if ((h & 63) == 62) begin
        // stuffed zero dropped
      end else begin
        if (b) m_acc = m_acc | 128;
        m_idx++;
        if (m_idx == 8) begin
          if (m_acc == 8'h7E || m_acc == 8'h7F || m_acc == 8'h1B) begin
            if (f) fail = 1; else begin ev = 1; ed = 8'h1B; m_pend.push_back(m_acc); end
          end else begin
            ed = m_acc;
            if (f) fail = 1; else ev = 1;
          end
          m_acc = 0; m_idx = 0;
        end else begin
          m_acc = m_acc >> 1;
        end
      end
    end
    check(ev, ed);
    if (fail) rx_n = 0;
    m_rx = rx_n;
    if (fail) m_ovr = 1; else if (clr) m_ovr = 0;
  endtask

  function automatic void add_flag();
    for (int i = 0; i < 8; i++) bq.push_back(bit'((8'h7E >> i) & 1));
    ones_run = 0;
  endfunction

  function automatic void add_byte(input int v);
    for (int i = 0; i < 8; i++) begin
      bit b;
      b = bit'((v >> i) & 1);
      bq.push_back(b);
      if (b) begin
        ones_run++;
        if (ones_run == 5) begin bq.push_back(1'b0); ones_run = 0; end
      end else ones_run = 0;
    end
  endfunction

  // full_idx selects one strobe; f1 = full on strobe cycle, f2 = full on the gap cycle
  task automatic send_q(input int full_idx, input bit f1, input bit f2);
    for (int i = 0; i < bq.size(); i++) begin
      cycle(1'b1, bq[i], (i == full_idx) && f1, 1'b0, 1'b0);
      cycle(1'b0, 1'b0, (i == full_idx) && f2, 1'b0, 1'b0);
    end
    bq.delete();
  endtask

  initial begin
    #(8 * 200000);
    n_bad++;
    $display("FAIL watchdog: got timeout, expected completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    // R9: reset state
    cur_req = "R9";
    for (int i = 0; i < 3; i++) cycle(0, 0, 0, 0, 1);

    // R4: pseudo-random noise before any frame
    cur_req = "R4";
    for (int i = 0; i < 60; i++) begin
      lfsr = (lfsr >> 1) ^ ((lfsr & 1) ? 32'hB400 : 0);
      bq.push_back(bit'(lfsr & 1));
    end
    send_q(-1, 0, 0);
    // make sure not receiving: abort run of ones
    for (int i = 0; i < 8; i++) bq.push_back(1'b1);
    send_q(-1, 0, 0);
    cur_req = "R4";
    add_byte(8'h55); add_byte(8'h12);
    send_q(-1, 0, 0);

    // R1, R6, R5: plain frame, including all-ones byte that needs stuffing
    cur_req = "R6";
    add_flag(); add_byte(8'hA5); add_byte(8'h3C); add_byte(8'h00); add_flag();
    send_q(-1, 0, 0);
    cur_req = "R5";
    add_flag(); add_byte(8'hFF); add_byte(8'hF8); add_byte(8'h3E); add_flag();
    send_q(-1, 0, 0);
    cur_req = "R1";
    add_flag(); add_flag(); add_byte(8'h81); add_flag();
    send_q(-1, 0, 0);

    // R7: control-valued data bytes
    cur_req = "R7";
    add_flag(); add_byte(8'h7E); add_byte(8'h7F); add_byte(8'h1B); add_byte(8'h1C); add_flag();
    send_q(-1, 0, 0);

    // R3: abort in mid frame, then data ignored
    cur_req = "R3";
    add_flag(); add_byte(8'h42);
    for (int i = 0; i < 7; i++) bq.push_back(1'b1);
    bq.push_back(1'b0);
    send_q(-1, 0, 0);
    cur_req = "R4";
    add_byte(8'h99); add_byte(8'h24);
    send_q(-1, 0, 0);

    // R2: FIFO full at delimiter
    cur_req = "R2";
    add_flag(); add_byte(8'h33);
    send_q(7, 1, 0);

    // R9: clear overrun
    cur_req = "R9";
    cycle(0, 0, 0, 1, 0);
    cycle(0, 0, 0, 0, 0);

    // R8: full on a data byte push
    cur_req = "R8";
    add_flag(); add_byte(8'h5A); add_byte(8'h66);
    send_q(15, 1, 0);
    cur_req = "R9";
    cycle(0, 0, 0, 1, 0);

    // R8: full on the deferred escaped byte (byte 0x7E spans strobes 8..16)
    cur_req = "R8";
    add_flag(); add_byte(8'h7E); add_byte(8'h11);
    send_q(16, 0, 1);
    // R8: overrun stays without clear
    cycle(0, 0, 0, 0, 0);
    cycle(0, 0, 0, 0, 0);

    // R9: clear coinciding with a failed push keeps overrun
    cur_req = "R9";
    add_flag();
    for (int i = 0; i < bq.size(); i++) begin
      cycle(1, bq[i], i == 7, i == 7, 0);
      cycle(0, 0, 0, 0, 0);
    end
    bq.delete();
    cycle(0, 0, 0, 1, 0);

    // R9: reset in mid frame
    add_flag(); add_byte(8'hC3);
    send_q(-1, 0, 0);
    cycle(0, 0, 0, 0, 1);
    cycle(0, 0, 0, 0, 0);
    cur_req = "R6";
    add_flag(); add_byte(8'h0F); add_flag();
    send_q(-1, 0, 0);

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

endmodule